// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block runs IEEE 802.3 clause 22 management frames toward external PHY devices on behalf of a processor. Software sees two 16-bit registers. The command register packs a PHY address, a PHY register number, a direction flag and a busy flag. The data register holds the value for a write, or receives the value returned by a read.

To write a PHY register, software stages the value in the data register. It then writes the command word with the write flag and the busy flag set. To read, software writes the command word with the busy flag set and the write flag clear. It then polls busy until it drops and collects the result from the data register.

On the line side the block drives MDC from a divider of the system clock. It presents MDIO as an output value, an output enable and an input. A 64-bit frame is shifted out MSB first. The enable is released during the read turnaround and the read data bits.

Top module: `mdio_master`

## Requirements
- R1: Command register layout, used on write and readback: bits 15:11 hold the PHY address, bits 10:6 hold the register number, bit 1 is the write flag (1 = write, 0 = read), and bit 0 is busy. Bits 5:2 read as 0. `reg_sel_i` = 0 selects the command register and 1 selects the data register.
- R2: A command write with bit 0 = 1 while idle starts a frame. Busy then reads 1 for exactly 128 × `MDC_HALF` clock cycles and then reads 0.
- R3: A command write with bit 0 = 0 stores the address, register and direction fields but starts no frame. Busy stays 0 and MDC does not toggle.
- R4: While busy is 1, writes to the command register and to the data register are ignored. The frame in progress, the command readback fields and the staged data are all unchanged.
- R5: A write frame is 32 ones, then 01, then opcode 01, then 5 address bits and 5 register bits MSB first, then turnaround 10, then the 16 data bits held in the data register at launch, MSB first. The output enable is 1 for all 64 bits.
- R6: A read frame carries the same preamble, start, address and register bits with opcode 10. The output enable is 1 for the first 46 bits and 0 for the last 18 bits (turnaround and data).
- R7: During a read, the 16 data bits are sampled from `mdio_i` at the rising edges of MDC, MSB first. The value is in the data register once busy reads 0.
- R8: MDC has a period of 2 × `MDC_HALF` clock cycles during a frame and is held low when idle. `mdio_o` never changes on a clock edge where MDC rises, and the output enable is 0 when idle.
- R9: After reset both registers read 0, and MDC and the output enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 command, 1 data |
| reg_wdata_i | input | 16 | Register write data |
| cmd_rdata_o | output | 16 | Command register readback |
| data_rdata_o | output | 16 | Data register readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach is a register write that lands in the middle of a running frame. Such a write must leave untouched the bits still to be shifted, the captured read data and the command readback. The bench reaches it by launching a frame, waiting a fixed number of cycles into the address and data fields, and writing conflicting values to both registers. It then compares the full 64-bit frame recorded by its PHY model, and both readbacks, against values computed from the original command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regad;
    logic       wr;
  } cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(cmd_t c, logic [15:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.wr ? 2'b01 : 2'b10;
    ta = c.wr ? 2'b10 : 2'b11;
    return {32'hffff_ffff, 2'b01, op, c.phy, c.regad, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == LAST);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  wr_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mdio_o,
  output logic                  oe_o,
  output logic [15:0]           rdata_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      bit_q;
  logic [CNT_W-1:0]      bit_nx;
  logic                  busy_q, oe_q, wr_q;
  logic [15:0]           cap_q;

  assign bit_nx  = bit_q + 1'b1;
  assign done_o  = busy_q && fall_i && (bit_q == CNT_W'(FRAME_BITS - 1));
  assign busy_o  = busy_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign oe_o    = oe_q;
  assign rdata_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      cap_q  <= '0;
    end else if (start_i && !busy_q) begin
      sh_q   <= frame_i;
      bit_q  <= '0;
      busy_q <= 1'b1;
      oe_q   <= 1'b1;
      wr_q   <= wr_i;
    end else if (busy_q) begin
      // sample just ahead of the MDC rising edge
      if (rise_i && !wr_q && bit_q >= CNT_W'(DATA_IDX))
        cap_q <= {cap_q[14:0], mdio_i};
      // advance on MDC falling edge, far from the sampling edge
      if (done_o) begin
        busy_q <= 1'b0;
        oe_q   <= 1'b0;
      end else if (fall_i) begin
        bit_q <= bit_nx;
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        oe_q  <= wr_q || (bit_nx < CNT_W'(TA_IDX));
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] cmd_rdata_o,
  output logic [15:0] data_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t        cmd_q, cmd_new;
  logic [15:0] data_q;
  logic        busy, done, rise, fall, launch;
  logic [15:0] cap;
  logic [FRAME_BITS-1:0] frame;

  assign cmd_new = '{phy: reg_wdata_i[15:11], regad: reg_wdata_i[10:6], wr: reg_wdata_i[1]};
  assign launch  = reg_we_i && !reg_sel_i && reg_wdata_i[0] && !busy;
  assign frame   = build_frame(cmd_new, data_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (reg_we_i && !busy) begin
        if (reg_sel_i) data_q <= reg_wdata_i;
        else           cmd_q  <= cmd_new;
      end
      if (done && !cmd_q.wr) data_q <= cap;
    end
  end

  assign cmd_rdata_o  = {cmd_q.phy, cmd_q.regad, 4'b0000, cmd_q.wr, busy};
  assign data_rdata_o = data_q;

  mdio_clk_div #(.HALF(MDC_HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame_eng u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch),
    .frame_i(frame),
    .wr_i   (cmd_new.wr),
    .rise_i (rise),
    .fall_i (fall),
    .mdio_i (mdio_i),
    .busy_o (busy),
    .done_o (done),
    .mdio_o (mdio_o),
    .oe_o   (mdio_oe_o),
    .rdata_o(cap)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        reg_sel_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] cmd_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  logic busy;
  logic cmd_wr;
  assign busy   = cmd_rdata_o[0];
  assign cmd_wr = reg_we_i && !reg_sel_i;

  AST_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy && reg_wdata_i[0]) |=> busy); // R2

  AST_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy && !reg_wdata_i[0]) |=> !busy); // R3

  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy) |=> $stable(cmd_rdata_o[15:1])); // R4

  AST_IDLE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o); // R8

  AST_IDLE_OE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o); // R8

  AST_MDIO_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o)); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdata_o[5:2] == 4'b0000); // R1
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .cmd_rdata_o(cmd_rdata_o),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int HALF = 2;
  localparam int TXN  = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] cmd_rd, data_rd;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int errors = 0;
  int checks = 0;

  logic [63:0] cap_bits, cap_oe;
  logic [15:0] phy_val = '0;
  int          phy_cnt = 0;

  always #4 clk = ~clk;

  mdio_master #(.MDC_HALF(HALF)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_sel_i   (sel),
    .reg_wdata_i (wdata),
    .cmd_rdata_o (cmd_rd),
    .data_rdata_o(data_rd),
    .mdc_o       (mdc),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (mdio_in)
  );

  // PHY model: record line at MDC rise, drive read data after MDC fall
  always @(posedge mdc) begin
    #1;
    if (phy_cnt < 64) begin
      cap_bits[63-phy_cnt] = mdio_out;
      cap_oe[63-phy_cnt]   = mdio_oe;
    end
    phy_cnt = phy_cnt + 1;
  end

  always @(negedge mdc) begin
    if (phy_cnt >= 48 && phy_cnt < 64) mdio_in = phy_val[63-phy_cnt];
    else mdio_in = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic s, input logic [15:0] v);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [15:0] cmd_word(input logic [4:0] p, input logic [4:0] r,
                                           input logic w, input logic b);
    return {p, r, 4'b0000, w, b};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [4:0] p, input logic [4:0] r,
                                            input logic w, input logic [15:0] d);
    return {32'hffff_ffff, 2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b00), d};
  endfunction

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rd[0] && n < 4 * TXN) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int n;
    reg_write(1'b1, d);
    phy_cnt = 0;
    reg_write(1'b0, cmd_word(p, r, 1'b1, 1'b1));
    wait_idle(n);
    chk("R2 busy length", 64'(n), 64'(TXN));
    chk("R5 write frame", cap_bits, exp_frame(p, r, 1'b1, d));
    chk("R5 write oe", cap_oe, '1);
    chk("R1 cmd readback", 64'(cmd_rd), 64'(cmd_word(p, r, 1'b1, 1'b0)));
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
    int n;
    phy_val = v;
    phy_cnt = 0;
    reg_write(1'b0, cmd_word(p, r, 1'b0, 1'b1));
    wait_idle(n);
    chk("R2 busy length", 64'(n), 64'(TXN));
    chk("R6 read header", 64'(cap_bits[63:18]), 64'(exp_frame(p, r, 1'b0, 16'h0) >> 18));
    chk("R6 read oe", cap_oe, {46'h3fff_ffff_ffff, 18'h0});
    chk("R7 read data", 64'(data_rd), 64'(v));
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 cmd reset", 64'(cmd_rd), 64'h0);
    chk("R9 data reset", 64'(data_rd), 64'h0);
    chk("R9 mdc/oe reset", {62'h0, mdc, mdio_oe}, 64'h0);

    // R5 / R2: write sweep over every PHY address
    for (int p = 0; p < 32; p++)
      do_write(5'(p), 5'(31 - p), 16'(p * 16'h0871 + 16'h1234));
    // R6 / R7: read sweep over every PHY address
    for (int p = 0; p < 32; p++)
      do_read(5'(p), 5'(p ^ 21), 16'(16'hffff - p * 16'h0a3d));
    do_read(5'd31, 5'd31, 16'h0000);
    do_read(5'd0, 5'd0, 16'hffff);

    // R3: command with busy clear starts nothing
    begin
      phy_cnt = 0;
      reg_write(1'b0, cmd_word(5'd9, 5'd4, 1'b1, 1'b0));
      repeat (4 * HALF + 10) @(negedge clk);
      chk("R3 no launch busy", 64'(cmd_rd[0]), 64'h0);
      chk("R3 no mdc edges", 64'(phy_cnt), 64'h0);
      chk("R3 fields stored", 64'(cmd_rd), 64'(cmd_word(5'd9, 5'd4, 1'b1, 1'b0)));
    end

    // R4: writes during a write frame are ignored
    begin
      int n;
      reg_write(1'b1, 16'hc3a5);
      phy_cnt = 0;
      reg_write(1'b0, cmd_word(5'd17, 5'd11, 1'b1, 1'b1));
      repeat (80 * HALF) @(negedge clk);
      reg_write(1'b1, 16'h5a5a);
      reg_write(1'b0, cmd_word(5'd2, 5'd30, 1'b0, 1'b1));
      chk("R4 cmd unchanged mid-frame", 64'(cmd_rd), 64'(cmd_word(5'd17, 5'd11, 1'b1, 1'b1)));
      wait_idle(n);
      chk("R4 frame undisturbed", cap_bits, exp_frame(5'd17, 5'd11, 1'b1, 16'hc3a5));
      chk("R4 data unchanged", 64'(data_rd), 64'h0000_0000_0000_c3a5);
      chk("R4 cmd after", 64'(cmd_rd), 64'(cmd_word(5'd17, 5'd11, 1'b1, 1'b0)));
    end

    // R4 / R7: writes during a read frame do not corrupt the result
    begin
      int n;
      phy_val = 16'h9e37;
      phy_cnt = 0;
      reg_write(1'b0, cmd_word(5'd6, 5'd1, 1'b0, 1'b1));
      repeat (100 * HALF) @(negedge clk);
      reg_write(1'b1, 16'h0000);
      wait_idle(n);
      chk("R4 read result kept", 64'(data_rd), 64'h9e37);
    end

    // R8: MDC period and idle level
    begin
      int t_rise0, t_rise1;
      phy_cnt = 0;
      reg_write(1'b0, cmd_word(5'd1, 5'd2, 1'b1, 1'b1));
      t_rise0 = 0;
      while (!mdc) begin @(negedge clk); t_rise0++; end
      t_rise1 = 0;
      while (mdc) begin @(negedge clk); t_rise1++; end
      while (!mdc) begin @(negedge clk); t_rise1++; end
      chk("R8 mdc period", 64'(t_rise1), 64'(2 * HALF));
      begin int n; wait_idle(n); end
      repeat (3 * HALF) @(negedge clk);
      chk("R8 mdc idle low", {63'h0, mdc}, 64'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule